// File: doc/BRIEF.md
# Two-Channel Scalar Block Texture Decoder

This block turns one texel of a block-compressed scalar texture into its 8-bit value. Each compressed channel sub-block covers a 4x4 tile of texels in 64 bits. It holds two 8-bit anchor values and sixteen 3-bit palette codes, one for each texel. The decoder builds the eight-entry palette from the two anchors and then picks the entry that the requested texel's code names.

A mode input selects how the 128-bit request word is used. In single-channel mode only the low 64-bit sub-block is decoded, and the Y output stays at zero. In dual-channel mode the upper 64 bits form a second, independent sub-block for the Y channel. Both sub-blocks are decoded with the same texel position, which gives a two-component value such as a tangent-space normal. Any of 64 distinct (x, y) pairs can then occur inside one tile, at 8 bits per texel overall.

Requests are accepted on every cycle. Each request produces a result exactly two cycles later, with a matching valid strobe. When no result is delivered, the outputs keep their last value.

Top module: `scalar_blk_dec`

## Requirements
- R1: While rst_n is low, rsp_valid, rsp_x and rsp_y are all 0.
- R2: rsp_valid is high in the cycle two clock edges after an edge that sampled req_valid high, and low otherwise. A new request may be given on every cycle.
- R3: The X sub-block is req_block[63:0] and the Y sub-block is req_block[127:64]. Within a sub-block, anchor A is bits [7:0] and anchor B is bits [15:8]. The 3-bit code of texel t (0 to 15) sits at bits [16+3t+2 : 16+3t].
- R4: Code 0 returns anchor A and code 1 returns anchor B, whatever the order of the anchors.
- R5: When A > B, code c in 2..7 returns floor(((7-k)*A + k*B + 3) / 7), where k = c-1.
- R6: When A <= B, code c in 2..5 returns floor(((5-k)*A + k*B + 2) / 5), where k = c-1.
- R7: When A <= B, code 6 returns 0 and code 7 returns 255.
- R8: With req_dual = 1, rsp_y is the decode of the Y sub-block at the same texel. The rules R4 to R7 apply to it independently of X.
- R9: With req_dual = 0, rsp_y is 0 in the response, whatever the upper 64 bits hold.
- R10: In a cycle where rsp_valid is low, rsp_x and rsp_y keep their previous values. Inputs presented while req_valid is low therefore change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_dual | input | 1 | 1 = dual-channel decode, 0 = single-channel |
| req_block | input | 128 | Compressed block: Y sub-block high, X sub-block low |
| req_texel | input | 4 | Texel position in the 4x4 tile, row-major |
| rsp_valid | output | 1 | Result strobe, two cycles after the request |
| rsp_x | output | 8 | Decoded X (single-channel) value |
| rsp_y | output | 8 | Decoded Y value, 0 in single-channel mode |

## Verification
The bench builds the block with its default parameters: 8-bit anchors, 3-bit codes and 16 texels. With these values every one of the eight palette codes, both anchor orderings, and every code position inside the 48-bit code field can be reached directly. Directed tiles drive each code at each texel position. They use descending, ascending, equal and extreme (0/255) anchor pairs, where the equal-anchor case falls into the six-step palette. A long randomized run follows, which mixes modes, gaps and back-to-back requests.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
   localparam int SBD_VAL_W  = 8;
   localparam int SBD_CODE_W = 3;
   localparam int SBD_TEXELS = 16;

   typedef enum logic {
      SBD_MODE_SINGLE = 1'b0,
      SBD_MODE_DUAL   = 1'b1
   } sbd_mode_e;
endpackage

// File: rtl/sbd_field_pick.sv
module sbd_field_pick #(
   parameter int VAL_W  = sbd_pkg::SBD_VAL_W,
   parameter int CODE_W = sbd_pkg::SBD_CODE_W,
   parameter int TEXELS = sbd_pkg::SBD_TEXELS,
   localparam int SUB_W  = 2*VAL_W + CODE_W*TEXELS,
   localparam int TIDX_W = $clog2(TEXELS)
) (
   input  logic [SUB_W-1:0]  sub_blk,
   input  logic [TIDX_W-1:0] texel,
   output logic [VAL_W-1:0]  anchor_a,
   output logic [VAL_W-1:0]  anchor_b,
   output logic [CODE_W-1:0] code
);
   localparam int CODE_BASE = 2*VAL_W;

   assign anchor_a = sub_blk[VAL_W-1:0];
   assign anchor_b = sub_blk[2*VAL_W-1:VAL_W];

   always_comb begin
      int base;
      base = CODE_BASE + CODE_W*int'(texel);
      code = sub_blk[base +: CODE_W];
   end
endmodule

// File: rtl/sbd_palette_eval.sv
module sbd_palette_eval #(
   parameter int VAL_W  = sbd_pkg::SBD_VAL_W,
   parameter int CODE_W = sbd_pkg::SBD_CODE_W
) (
   input  logic [VAL_W-1:0]  anchor_a,
   input  logic [VAL_W-1:0]  anchor_b,
   input  logic [CODE_W-1:0] code,
   output logic [VAL_W-1:0]  value
);
   localparam int ENTRIES      = 1 << CODE_W;
   localparam int WIDE_STEPS   = ENTRIES - 1;
   localparam int NARROW_STEPS = ENTRIES - 3;
   localparam int NUM_W        = VAL_W + CODE_W;

   if (CODE_W < 3) begin : g_bad_code_w
      $error("sbd_palette_eval: CODE_W must be at least 3");
   end
   if (VAL_W < 2) begin : g_bad_val_w
      $error("sbd_palette_eval: VAL_W must be at least 2");
   end

   logic             wide_mode;
   logic [VAL_W-1:0] palette [ENTRIES];

   assign wide_mode = anchor_a > anchor_b;

   for (genvar c = 0; c < ENTRIES; c++) begin : g_entry
      if (c == 0) begin : g_anchor_a
         assign palette[c] = anchor_a;
      end else if (c == 1) begin : g_anchor_b
         assign palette[c] = anchor_b;
      end else begin : g_mid
         localparam int K = c - 1;
         logic [NUM_W-1:0] wide_num;
         logic [VAL_W-1:0] wide_val;
         logic [VAL_W-1:0] narrow_val;

         assign wide_num = NUM_W'(WIDE_STEPS - K) * NUM_W'(anchor_a)
                         + NUM_W'(K) * NUM_W'(anchor_b)
                         + NUM_W'(WIDE_STEPS / 2);
         assign wide_val = VAL_W'(wide_num / NUM_W'(WIDE_STEPS));

         if (c <= NARROW_STEPS) begin : g_narrow_interp
            logic [NUM_W-1:0] narrow_num;
            assign narrow_num = NUM_W'(NARROW_STEPS - K) * NUM_W'(anchor_a)
                              + NUM_W'(K) * NUM_W'(anchor_b)
                              + NUM_W'(NARROW_STEPS / 2);
            assign narrow_val = VAL_W'(narrow_num / NUM_W'(NARROW_STEPS));
         end else if (c == ENTRIES - 2) begin : g_narrow_floor
            assign narrow_val = '0;
         end else begin : g_narrow_ceil
            assign narrow_val = '1;
         end

         assign palette[c] = wide_mode ? wide_val : narrow_val;
      end
   end

   assign value = palette[code];
endmodule

// File: rtl/sbd_channel.sv
module sbd_channel #(
   parameter int VAL_W  = sbd_pkg::SBD_VAL_W,
   parameter int CODE_W = sbd_pkg::SBD_CODE_W,
   parameter int TEXELS = sbd_pkg::SBD_TEXELS,
   localparam int SUB_W  = 2*VAL_W + CODE_W*TEXELS,
   localparam int TIDX_W = $clog2(TEXELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_s1,
   input  logic              load_s2,
   input  logic              zero_s2,
   input  logic [SUB_W-1:0]  sub_blk,
   input  logic [TIDX_W-1:0] texel,
   output logic [VAL_W-1:0]  value
);
   logic [VAL_W-1:0]  pick_a, pick_b;
   logic [CODE_W-1:0] pick_code;
   logic [VAL_W-1:0]  s1_a, s1_b;
   logic [CODE_W-1:0] s1_code;
   logic [VAL_W-1:0]  pal_value;

   sbd_field_pick #(.VAL_W(VAL_W), .CODE_W(CODE_W), .TEXELS(TEXELS)) pick_i (
      .sub_blk  (sub_blk),
      .texel    (texel),
      .anchor_a (pick_a),
      .anchor_b (pick_b),
      .code     (pick_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_a    <= '0;
         s1_b    <= '0;
         s1_code <= '0;
      end else if (load_s1) begin
         s1_a    <= pick_a;
         s1_b    <= pick_b;
         s1_code <= pick_code;
      end
   end

   sbd_palette_eval #(.VAL_W(VAL_W), .CODE_W(CODE_W)) eval_i (
      .anchor_a (s1_a),
      .anchor_b (s1_b),
      .code     (s1_code),
      .value    (pal_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (load_s2) begin
         value <= zero_s2 ? '0 : pal_value;
      end
   end
endmodule

// File: rtl/scalar_blk_dec.sv
module scalar_blk_dec #(
   parameter int VAL_W  = sbd_pkg::SBD_VAL_W,
   parameter int CODE_W = sbd_pkg::SBD_CODE_W,
   parameter int TEXELS = sbd_pkg::SBD_TEXELS,
   localparam int SUB_W  = 2*VAL_W + CODE_W*TEXELS,
   localparam int BLK_W  = 2*SUB_W,
   localparam int TIDX_W = $clog2(TEXELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_dual,
   input  logic [BLK_W-1:0]  req_block,
   input  logic [TIDX_W-1:0] req_texel,
   output logic              rsp_valid,
   output logic [VAL_W-1:0]  rsp_x,
   output logic [VAL_W-1:0]  rsp_y
);
   import sbd_pkg::*;

   localparam int NUM_CH = 2;

   if (TEXELS < 2 || (1 << TIDX_W) != TEXELS) begin : g_bad_texels
      $error("scalar_blk_dec: TEXELS must be a power of two");
   end

   logic      s1_valid, s2_valid;
   sbd_mode_e s1_mode;
   logic [VAL_W-1:0] ch_value [NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s2_valid <= 1'b0;
         s1_mode  <= SBD_MODE_SINGLE;
      end else begin
         s1_valid <= req_valid;
         s2_valid <= s1_valid;
         if (req_valid) begin
            s1_mode <= req_dual ? SBD_MODE_DUAL : SBD_MODE_SINGLE;
         end
      end
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic zero_out;
      if (ch == 0) begin : g_primary
         assign zero_out = 1'b0;
      end else begin : g_secondary
         assign zero_out = (s1_mode == SBD_MODE_SINGLE);
      end

      sbd_channel #(.VAL_W(VAL_W), .CODE_W(CODE_W), .TEXELS(TEXELS)) chan_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_s1 (req_valid),
         .load_s2 (s1_valid),
         .zero_s2 (zero_out),
         .sub_blk (req_block[ch*SUB_W +: SUB_W]),
         .texel   (req_texel),
         .value   (ch_value[ch])
      );
   end

   assign rsp_valid = s2_valid;
   assign rsp_x     = ch_value[0];
   assign rsp_y     = ch_value[1];
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
   parameter int VAL_W  = 8,
   parameter int CODE_W = 3,
   parameter int TEXELS = 16,
   localparam int SUB_W  = 2*VAL_W + CODE_W*TEXELS,
   localparam int BLK_W  = 2*SUB_W,
   localparam int TIDX_W = $clog2(TEXELS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_dual,
   input logic [BLK_W-1:0]  req_block,
   input logic [TIDX_W-1:0] req_texel,
   input logic              rsp_valid,
   input logic [VAL_W-1:0]  rsp_x,
   input logic [VAL_W-1:0]  rsp_y
);
   localparam int ENTRIES = 1 << CODE_W;

   logic              d1_valid, d2_valid, d1_dual, d2_dual;
   logic [SUB_W-1:0]  d1_sub, d2_sub;
   logic [TIDX_W-1:0] d1_tex, d2_tex;
   logic [1:0]        warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d1_valid <= 1'b0; d2_valid <= 1'b0;
         d1_dual  <= 1'b0; d2_dual  <= 1'b0;
         d1_sub   <= '0;   d2_sub   <= '0;
         d1_tex   <= '0;   d2_tex   <= '0;
         warm     <= '0;
      end else begin
         d1_valid <= req_valid; d2_valid <= d1_valid;
         d1_dual  <= req_dual;  d2_dual  <= d1_dual;
         d1_sub   <= req_block[SUB_W-1:0]; d2_sub <= d1_sub;
         d1_tex   <= req_texel; d2_tex <= d1_tex;
         if (warm != 2'd2) warm <= warm + 2'd1;
      end
   end

   logic              ready;
   logic [VAL_W-1:0]  ref_a, ref_b;
   logic [CODE_W-1:0] ref_code;

   assign ready = (warm == 2'd2);
   assign ref_a = d2_sub[VAL_W-1:0];
   assign ref_b = d2_sub[2*VAL_W-1:VAL_W];
   always_comb ref_code = d2_sub[2*VAL_W + CODE_W*int'(d2_tex) +: CODE_W];

   AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (rsp_valid == d2_valid)); // R2

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> ($stable(rsp_x) && $stable(rsp_y))); // R10

   AST_ANCHOR_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && rsp_valid && ref_code == '0) |-> (rsp_x == ref_a)); // R4

   AST_NARROW_CONSTANTS: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && rsp_valid && ref_a <= ref_b && ref_code >= CODE_W'(ENTRIES-2))
      |-> (rsp_x == ((ref_code == CODE_W'(ENTRIES-2)) ? '0 : '1))); // R7

   AST_WIDE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && rsp_valid && ref_a > ref_b) |-> (rsp_x <= ref_a && rsp_x >= ref_b)); // R5

   AST_SINGLE_Y_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && rsp_valid && !d2_dual) |-> (rsp_y == '0)); // R9
endmodule

bind scalar_blk_dec sbd_checker #(.VAL_W(VAL_W), .CODE_W(CODE_W), .TEXELS(TEXELS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_dual  (req_dual),
   .req_block (req_block),
   .req_texel (req_texel),
   .rsp_valid (rsp_valid),
   .rsp_x     (rsp_x),
   .rsp_y     (rsp_y)
);

// File: tb/scalar_blk_dec_tb_top.sv
module scalar_blk_dec_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_dual = 1'b0;
   logic [127:0] req_block = '0;
   logic [3:0]   req_texel = '0;
   logic         rsp_valid;
   logic [7:0]   rsp_x, rsp_y;
   string        req_tag = "";

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scalar_blk_dec dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dual(req_dual),
      .req_block(req_block), .req_texel(req_texel),
      .rsp_valid(rsp_valid), .rsp_x(rsp_x), .rsp_y(rsp_y)
   );

   function automatic void check(string tag, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endfunction

   // Reference decode of one sub-block per the requirement formulas.
   function automatic int ref_decode(logic [63:0] sb, int t);
      int a, b, c, k;
      a = int'(sb[7:0]);
      b = int'(sb[15:8]);
      c = int'(sb[16 + 3*t +: 3]);
      k = c - 1;
      if (c == 0) return a;
      if (c == 1) return b;
      if (a > b) return ((7-k)*a + k*b + 3) / 7;
      if (c == 6) return 0;
      if (c == 7) return 255;
      return ((5-k)*a + k*b + 2) / 5;
   endfunction

   function automatic string code_tag(logic [63:0] sb, int t);
      int c;
      c = int'(sb[16 + 3*t +: 3]);
      if (c < 2) return "R4";
      if (sb[7:0] > sb[15:8]) return "R5";
      if (c >= 6) return "R7";
      return "R6";
   endfunction

   function automatic logic [63:0] mk_sub(int a, int b, logic [47:0] codes);
      return {codes, 8'(b), 8'(a)};
   endfunction

   // Reference model: one pending request, last delivered outputs.
   bit          p_valid = 0, p_dual = 0;
   logic [127:0] p_blk = '0;
   int          p_tex = 0;
   string       p_tag = "";
   int          last_x = 0, last_y = 0;

   always @(posedge clk) begin
      #1;
      if (!rst_n) begin
         p_valid = 0;
         last_x = 0;
         last_y = 0;
      end else if (!done) begin
         check("R2", "rsp_valid", int'(rsp_valid), int'(p_valid));
         if (p_valid) begin
            int ex, ey;
            string tx;
            ex = ref_decode(p_blk[63:0], p_tex);
            ey = p_dual ? ref_decode(p_blk[127:64], p_tex) : 0;
            tx = (p_tag != "") ? p_tag : code_tag(p_blk[63:0], p_tex);
            check(tx, "rsp_x", int'(rsp_x), ex);
            check(p_dual ? "R8" : "R9", "rsp_y", int'(rsp_y), ey);
            last_x = ex;
            last_y = ey;
         end else begin
            check("R10", "rsp_x hold", int'(rsp_x), last_x);
            check("R10", "rsp_y hold", int'(rsp_y), last_y);
         end
         p_valid = req_valid;
         p_dual  = req_dual;
         p_blk   = req_block;
         p_tex   = int'(req_texel);
         p_tag   = req_tag;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic send(bit v, bit dual, logic [127:0] blk, int t, string tag);
      @(negedge clk);
      req_valid = v;
      req_dual  = dual;
      req_block = blk;
      req_texel = 4'(t);
      req_tag   = tag;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         send(1'b0, 1'b0, {$urandom, $urandom, $urandom, $urandom}, int'($urandom_range(15)), "");
      end
   endtask

   // Code of texel t is t mod 8, so every code appears twice.
   task automatic tile_sweep(int a, int b, bit dual, int ya, int yb);
      logic [47:0] codes, ycodes;
      for (int t = 0; t < 16; t++) begin
         codes[3*t +: 3]  = 3'(t % 8);
         ycodes[3*t +: 3] = 3'(7 - (t % 8));
      end
      for (int t = 0; t < 16; t++) begin
         send(1'b1, dual, {mk_sub(ya, yb, ycodes), mk_sub(a, b, codes)}, t, "");
      end
   endtask

   initial begin
      // R1: outputs at reset
      repeat (3) @(negedge clk);
      check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
      check("R1", "rsp_x in reset", int'(rsp_x), 0);
      check("R1", "rsp_y in reset", int'(rsp_y), 0);
      rst_n = 1'b1;
      idle(2);

      // R5/R6/R7/R4 in single mode with garbage in the upper half (R9)
      tile_sweep(200, 40, 1'b0, 17, 99);
      tile_sweep(30, 220, 1'b0, 250, 3);
      tile_sweep(90, 90, 1'b0, 1, 2);
      tile_sweep(255, 0, 1'b0, 0, 255);
      tile_sweep(0, 255, 1'b0, 255, 0);
      idle(3);

      // R8: dual mode, independent orderings per channel
      tile_sweep(200, 40, 1'b1, 30, 220);
      tile_sweep(30, 220, 1'b1, 255, 0);
      tile_sweep(77, 77, 1'b1, 181, 6);
      idle(2);

      // R3: field positions, random codes over every texel
      for (int r = 0; r < 6; r++) begin
         logic [47:0] codes;
         codes = {$urandom, $urandom};
         for (int t = 0; t < 16; t++) begin
            send(1'b1, r[0], {$urandom, $urandom, mk_sub(int'($urandom_range(255)),
                 int'($urandom_range(255)), codes)}, t, "R3");
         end
      end

      // R10 / R2: random mix of gaps, modes and back-to-back requests
      for (int i = 0; i < 600; i++) begin
         send($urandom_range(3) != 0, $urandom_range(1) == 1,
              {$urandom, $urandom, $urandom, $urandom}, int'($urandom_range(15)), "");
      end
      idle(4);

      // R1: reset again mid-traffic
      send(1'b1, 1'b1, {$urandom, $urandom, $urandom, $urandom}, 5, "");
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      #1;
      check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
      check("R1", "rsp_x after reset", int'(rsp_x), 0);
      check("R1", "rsp_y after reset", int'(rsp_y), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule